// File: doc/BRIEF.md
# Task Microaddress Register File

This block holds one 12-bit microaddress for each of eight tasks and gives a host byte-wide access to them. The host writes through two strobed byte ports. The high port carries a 3-bit register index and the upper five data bits. The low port carries the lower seven data bits, and writing it commits the assembled word into the selected register. Data bits on both write ports travel in ones' complement form. The index field does not.

The host reads through two combinational byte outputs. The register shown is the one named by the most recently latched index. The low output gives the complement of data bits 7:0. The high output gives the complement of data bits 11:8 in its low nibble. Its upper nibble carries a 4-bit bank identifier, which is not complemented, so software can confirm which bank answered.

Top module: `tpc_port_regs`

## Requirements
- R1: After reset every register holds zero and the latched index is 0, so rd_lo_o reads 8'hFF and rd_hi_o reads {bank_id_i, 4'hF}.
- R2: A high-port write latches the index from hi_data_i[7:5], taken as is, and the data bits 11:7 as ~hi_data_i[4:0]. A high-port write alone changes no stored register.
- R3: A low-port write stores {latched bits 11:7, ~lo_data_i[7:1]} into the register named by the latched index.
- R4: Bit 0 of lo_data_i has no effect on the stored value.
- R5: The outputs are combinational from the register named by the latched index. rd_lo_o = ~data[7:0] and rd_hi_o[3:0] = ~data[11:8]. With no strobe active the outputs hold their values.
- R6: rd_hi_o[7:4] equals bank_id_i, not complemented, and follows it without a clock edge.
- R7: When both strobes are active in the same cycle, the commit uses the index and upper bits from that cycle's high-port data.
- R8: Repeated low-port writes with no high-port write in between reuse the same latched index and upper bits.
- R9: A commit changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_id_i | input | 4 | Bank identifier returned on read |
| hi_wr_i | input | 1 | High write port strobe |
| hi_data_i | input | 8 | Index [7:5], complemented data 11:7 [4:0] |
| lo_wr_i | input | 1 | Low write port strobe, commits the word |
| lo_data_i | input | 8 | Complemented data 6:0 in [7:1], bit 0 ignored |
| rd_lo_o | output | 8 | Complemented data 7:0 of the selected register |
| rd_hi_o | output | 8 | {bank_id_i, complemented data 11:8} |

## Verification
The bench uses the default parameters: eight registers, 12-bit data and byte ports. With these values the index field is three bits wide and exactly one data bit crosses from the high port into the low read byte. A few hundred random operations, together with a full readback, therefore reach every register, both index extremes and that carried bit. Directed cases cover all-ones and all-zeros words, simultaneous strobes, toggling the ignored low bit, and changing the bank identifier between clock edges.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned DEF_NUM_REGS = 8;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_PORT_W   = 8;

  // port data travels inverted
  function automatic logic [31:0] port_inv(input logic [31:0] v);
    return ~v;
  endfunction
endpackage

// File: rtl/tpc_hi_latch.sv
module tpc_hi_latch #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned HI_W   = 5,
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic [PORT_W-1:0] hi_data_i,
  output logic [IDX_W-1:0]  idx_q_o,
  output logic [IDX_W-1:0]  idx_fwd_o,
  output logic [HI_W-1:0]   hbits_fwd_o
);
  logic [IDX_W-1:0] idx_q;
  logic [HI_W-1:0]  hbits_q;
  logic [IDX_W-1:0] idx_new;
  logic [HI_W-1:0]  hbits_new;

  assign idx_new   = hi_data_i[PORT_W-1 -: IDX_W];
  assign hbits_new = ~hi_data_i[HI_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      hbits_q <= '0;
    end else if (hi_wr_i) begin
      idx_q   <= idx_new;
      hbits_q <= hbits_new;
    end
  end

  // same-cycle high write takes part in a low-port commit
  assign idx_fwd_o   = hi_wr_i ? idx_new : idx_q;
  assign hbits_fwd_o = hi_wr_i ? hbits_new : hbits_q;
  assign idx_q_o     = idx_q;

  p_idx_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr_i |=> idx_q == $past(hi_data_i[PORT_W-1 -: IDX_W]));
  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_wr_i |=> $stable(idx_q) && $stable(hbits_q));
endmodule

// File: rtl/tpc_reg_bank.sv
module tpc_reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 12,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic [IDX_W-1:0]                 widx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  logic [NUM_REGS-1:0] we;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign we[g] = commit_i && (widx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_o[g] <= '0;
      else if (we[g]) regs_o[g] <= wdata_i;
    end
  end

  p_one_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  p_commit_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> regs_o[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/tpc_read_fmt.sv
module tpc_read_fmt #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned PORT_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned UP_W    = DATA_W - PORT_W,
  localparam int unsigned BANK_W  = PORT_W - UP_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [IDX_W-1:0]                ridx_i,
  input  logic [BANK_W-1:0]               bank_i,
  output logic [PORT_W-1:0]               rd_lo_o,
  output logic [PORT_W-1:0]               rd_hi_o
);
  logic [DATA_W-1:0] sel;

  assign sel     = regs_i[ridx_i];
  assign rd_lo_o = ~sel[PORT_W-1:0];
  assign rd_hi_o = {bank_i, ~sel[DATA_W-1:PORT_W]};
endmodule

// File: rtl/tpc_port_regs.sv
module tpc_port_regs #(
  parameter int unsigned NUM_REGS = tpc_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = tpc_pkg::DEF_DATA_W,
  parameter int unsigned PORT_W   = tpc_pkg::DEF_PORT_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned HI_W    = PORT_W - IDX_W,
  localparam int unsigned LO_W    = DATA_W - HI_W,
  localparam int unsigned BANK_W  = 2 * PORT_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_id_i,
  input  logic              hi_wr_i,
  input  logic [PORT_W-1:0] hi_data_i,
  input  logic              lo_wr_i,
  input  logic [PORT_W-1:0] lo_data_i,
  output logic [PORT_W-1:0] rd_lo_o,
  output logic [PORT_W-1:0] rd_hi_o
);
  logic [IDX_W-1:0]                idx_q;
  logic [IDX_W-1:0]                idx_fwd;
  logic [HI_W-1:0]                 hbits_fwd;
  logic [DATA_W-1:0]               wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  if (PORT_W > LO_W) begin : g_lsb
    logic [PORT_W-LO_W-1:0] unused_lo_lsb;
    assign unused_lo_lsb = lo_data_i[PORT_W-LO_W-1:0];
  end

  assign wdata = {hbits_fwd, ~lo_data_i[PORT_W-1 -: LO_W]};

  tpc_hi_latch #(.IDX_W(IDX_W), .HI_W(HI_W), .PORT_W(PORT_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_wr_i     (hi_wr_i),
    .hi_data_i   (hi_data_i),
    .idx_q_o     (idx_q),
    .idx_fwd_o   (idx_fwd),
    .hbits_fwd_o (hbits_fwd)
  );

  tpc_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (lo_wr_i),
    .widx_i   (idx_fwd),
    .wdata_i  (wdata),
    .regs_o   (regs)
  );

  tpc_read_fmt #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_rd (
    .regs_i  (regs),
    .ridx_i  (idx_q),
    .bank_i  (bank_id_i),
    .rd_lo_o (rd_lo_o),
    .rd_hi_o (rd_hi_o)
  );

  p_lo_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> rd_lo_o[LO_W-1:0] == $past(lo_data_i[PORT_W-1 -: LO_W]));
  p_pair_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr_i && lo_wr_i) |=>
      {rd_hi_o[DATA_W-PORT_W-1:0], rd_lo_o[PORT_W-1:LO_W]} == $past(hi_data_i[HI_W-1:0]));
  p_quiet_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_wr_i && !lo_wr_i) |=> $stable(rd_lo_o));
endmodule

// File: tb/tpc_port_regs_tb.sv
`timescale 1ns/1ps
module tpc_port_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bank_id = 4'h5;
  logic       hi_wr = 1'b0, lo_wr = 1'b0;
  logic [7:0] hi_data = '0, lo_data = '0;
  logic [7:0] rd_lo, rd_hi;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [11:0] m_regs [8];
  logic [2:0]  m_idx;
  logic [4:0]  m_hb;

  always #2 clk = ~clk;

  tpc_port_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bank_id_i(bank_id),
    .hi_wr_i(hi_wr), .hi_data_i(hi_data),
    .lo_wr_i(lo_wr), .lo_data_i(lo_data),
    .rd_lo_o(rd_lo), .rd_hi_o(rd_hi)
  );

  function automatic logic [7:0] exp_lo();
    return ~m_regs[m_idx][7:0];
  endfunction
  function automatic logic [7:0] exp_hi();
    return {bank_id, ~m_regs[m_idx][11:8]};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk(req, rd_lo, exp_lo());
    chk(req, rd_hi, exp_hi());
  endtask

  task automatic op(input logic hw, input logic [7:0] hd, input logic lw, input logic [7:0] ld);
    logic [2:0] ni;
    logic [4:0] nh;
    @(negedge clk);
    hi_wr = hw; hi_data = hd; lo_wr = lw; lo_data = ld;
    @(posedge clk);
    ni = hw ? hd[7:5] : m_idx;
    nh = hw ? ~hd[4:0] : m_hb;
    if (lw) m_regs[ni] = {nh, ~ld[7:1]};
    m_idx = ni; m_hb = nh;
    #1;
    hi_wr = 1'b0; lo_wr = 1'b0;
  endtask

  function automatic logic [7:0] hi_byte(input logic [2:0] idx, input logic [11:0] v);
    return {idx, ~v[11:7]};
  endfunction
  function automatic logic [7:0] lo_byte(input logic [11:0] v, input logic lsb);
    return {~v[6:0], lsb};
  endfunction

  task automatic write_reg(input logic [2:0] idx, input logic [11:0] v, input logic lsb);
    op(1'b1, hi_byte(idx, v), 1'b0, 8'h00);
    op(1'b0, 8'h00, 1'b1, lo_byte(v, lsb));
  endtask

  task automatic sel(input logic [2:0] idx);
    op(1'b1, {idx, 5'h00}, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    m_idx = '0; m_hb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", rd_lo, 8'hFF);
    chk("R1", rd_hi, {bank_id, 4'hF});
    for (int i = 0; i < 8; i++) begin
      sel(3'(i));
      chk_out("R1");
    end

    // R3 directed commit, R5 format
    write_reg(3'd3, 12'hABC, 1'b0);
    chk_out("R3");
    chk("R5", rd_lo, 8'h43);
    chk("R5", rd_hi, {bank_id, 4'h5});
    write_reg(3'd7, 12'hFFF, 1'b1);
    chk("R3", rd_lo, 8'h00);
    write_reg(3'd0, 12'h000, 1'b1);
    chk("R3", rd_lo, 8'hFF);

    // R2 high write alone does not touch storage
    op(1'b1, hi_byte(3'd3, 12'h000), 1'b0, 8'h00);
    chk("R2", rd_lo, 8'h43);
    chk("R2", rd_hi, {bank_id, 4'h5});

    // R4 lsb ignored
    write_reg(3'd5, 12'h5A5, 1'b0);
    chk_out("R4");
    op(1'b0, 8'h00, 1'b1, lo_byte(12'h5A5, 1'b1));
    chk("R4", rd_lo, ~8'hA5);
    chk("R4", rd_hi, {bank_id, 4'hA});

    // R7 simultaneous strobes use the new high byte
    op(1'b1, hi_byte(3'd6, 12'h980), 1'b1, lo_byte(12'h07F, 1'b0));
    chk("R7", rd_lo, ~8'hFF);
    chk("R7", rd_hi, {bank_id, 4'h6});
    chk_out("R7");

    // R8 repeated low writes reuse latch
    op(1'b0, 8'h00, 1'b1, lo_byte(12'h011, 1'b0));
    chk("R8", rd_lo, ~8'h91);
    chk_out("R8");

    // R6 bank follows input with no edge
    @(negedge clk) bank_id = 4'hA;
    #1 chk("R6", rd_hi[7:4], 8'h0A);
    bank_id = 4'h3;
    #1 chk("R6", rd_hi[7:4], 8'h03);

    // R5 outputs hold with no strobes
    op(1'b0, 8'hFF, 1'b0, 8'hFF);
    chk_out("R5");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic hw, lw;
      hw = 1'($urandom);
      lw = 1'($urandom);
      if (n % 37 == 0) bank_id = 4'($urandom);
      op(hw, 8'($urandom), lw, 8'($urandom));
      chk_out(lw ? "R3" : "R5");
    end

    // R9 full readback
    for (int i = 0; i < 8; i++) begin
      sel(3'(i));
      chk_out("R9");
    end
    write_reg(3'd2, 12'h3C3, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sel(3'(i));
      chk_out("R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule